// File: doc/BRIEF.md
# Port Input Interrupt Selector

This block turns external port pins into eight independent interrupt sources. Each source, called a factor, has its own pin multiplexer over five candidate inputs. Four candidates are reached through a 2-bit code. The fifth is an alternate pin, chosen by an override bit that takes precedence over the code. The chosen pin is synchronized, and then either its edge or its level of a programmed polarity sets a sticky flag for that factor.

Software reaches the configuration through a byte-wide register port. A write happens on a clock edge while the write strobe is high. Reads are combinational from the address. Flags are cleared by writing ones to the flag register. The interrupt request output is the OR, over all factors, of each flag gated with its enable bit. The downstream interrupt controller does the prioritizing and vectoring.

Top module: `port_irq_selector`

## Requirements
- R1: While reset is held, every register (addresses 0 to 6) reads 0 and `irqOut` is low.
- R2: Addresses 0 to 5 read back the last byte written to them. Address 7 always reads 0, and writes to it change no other register.
- R3: Factor n takes its 2-bit code from register n/4 (address 0 or 1) at bits [2*(n%4)+1 : 2*(n%4)]. Code c selects the candidate pin `pinIn[5*n+c]`.
- R4: When bit n of address 2 is 1, factor n uses `pinIn[5*n+4]` whatever its 2-bit code.
- R5: A change on any candidate pin of factor n that is not currently selected leaves flag n unchanged.
- R6: In edge mode (bit n of address 3 is 1), the factor watches one edge of the selected pin. With polarity bit n of address 4 at 1 it watches the rising edge; with 0 it watches the falling edge. That edge sets flag n no later than the third rising clock edge after the pin changes. The opposite edge does not set the flag, and neither does holding the level.
- R7: In level mode (bit n of address 3 is 0), flag n is set while the selected pin is high (polarity 1) or low (polarity 0). If the flag is cleared while that level persists, it is set again on the next clock.
- R8: Flags read at address 6, bit n for factor n. Writing 1 to bit n of address 6 clears flag n.
- R9: `irqOut` is high exactly when some flag n is set and its enable bit n at address 5 is 1.
- R10: Changing the code or the override bit of a factor in edge mode never produces a flag from the difference between the old and new pin values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 40 | Candidate pins, five per factor; factor n at [5n+4:5n] |
| regAddr | input | 3 | Register address |
| regWrEn | input | 1 | Write strobe, captured on the rising clock edge |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for `regAddr` |
| flagOut | output | 8 | Sticky factor flags |
| irqOut | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: eight factors of five candidates each, behind a two-stage synchronizer. At that size every pair of factor and candidate can be crossed with all four trigger conditions in one sweep. The sweep covers 160 configurations. For each one it checks that a stray pin is ignored, that the right edge or level sets the flag, that clearing behaves correctly, and that enable gating works. Directed cases then switch the code and the override bit under a standing level difference to show that reconfiguration raises no flag, while a real edge afterwards still does.

// File: rtl/pisel_pkg.sv
package pisel_pkg;
  localparam int FACTORS = 8;
  localparam int CANDS = 5;
  localparam int SEL_W = 2;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int SEL_PER_REG = DATA_W / SEL_W;
  localparam int SEL_REGS = FACTORS / SEL_PER_REG;
  localparam int PIN_W = FACTORS * CANDS;

  localparam logic [ADDR_W-1:0] A_SEL0 = 3'd0;
  localparam logic [ADDR_W-1:0] A_SEL1 = 3'd1;
  localparam logic [ADDR_W-1:0] A_EXP  = 3'd2;
  localparam logic [ADDR_W-1:0] A_EDGE = 3'd3;
  localparam logic [ADDR_W-1:0] A_POL  = 3'd4;
  localparam logic [ADDR_W-1:0] A_EN   = 3'd5;
  localparam logic [ADDR_W-1:0] A_FLAG = 3'd6;

  typedef struct packed {
    logic [FACTORS-1:0] flagClr;
    logic [FACTORS-1:0] rearm;
  } pisel_strobe_t;
endpackage

// File: rtl/pisel_ctrl.sv
module pisel_ctrl
  import pisel_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [ADDR_W-1:0]          regAddr,
  input  logic                       regWrEn,
  input  logic [DATA_W-1:0]          regWrData,
  input  logic [FACTORS-1:0]         flagIn,
  output logic [DATA_W-1:0]          regRdData,
  output logic [FACTORS*SEL_W-1:0]   selCode,
  output logic [FACTORS-1:0]         expSel,
  output logic [FACTORS-1:0]         edgeMode,
  output logic [FACTORS-1:0]         polHigh,
  output logic [FACTORS-1:0]         intEn,
  output pisel_strobe_t              strobe
);
  logic [FACTORS*SEL_W-1:0] selReg;
  logic [FACTORS-1:0] expReg, edgeReg, polReg, enReg;
  logic [FACTORS-1:0] rearmNow, rearmQ, clrNow;

  genvar r;
  generate
    for (r = 0; r < SEL_REGS; r++) begin : g_selReg
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(r);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) selReg[r*DATA_W +: DATA_W] <= '0;
        else if (regWrEn && regAddr == MY_ADDR) selReg[r*DATA_W +: DATA_W] <= regWrData;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expReg  <= '0;
      edgeReg <= '0;
      polReg  <= '0;
      enReg   <= '0;
      rearmQ  <= '0;
    end else begin
      rearmQ <= rearmNow;
      if (regWrEn) begin
        case (regAddr)
          A_EXP:   expReg  <= regWrData;
          A_EDGE:  edgeReg <= regWrData;
          A_POL:   polReg  <= regWrData;
          A_EN:    enReg   <= regWrData;
          default: ;
        endcase
      end
    end
  end

  // per-factor change detection: any field of the factor differs from the write
  genvar n;
  generate
    for (n = 0; n < FACTORS; n++) begin : g_chg
      localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(n / SEL_PER_REG);
      localparam int OFS = (n % SEL_PER_REG) * SEL_W;
      logic selChg, bitChg;
      always_comb begin
        selChg = regWrEn && regAddr == SEL_ADDR &&
                 regWrData[OFS +: SEL_W] != selReg[n*SEL_W +: SEL_W];
        bitChg = 1'b0;
        if (regWrEn) begin
          case (regAddr)
            A_EXP:   bitChg = regWrData[n] != expReg[n];
            A_EDGE:  bitChg = regWrData[n] != edgeReg[n];
            A_POL:   bitChg = regWrData[n] != polReg[n];
            default: bitChg = 1'b0;
          endcase
        end
      end
      assign rearmNow[n] = selChg || bitChg;
    end
  endgenerate

  assign clrNow = (regWrEn && regAddr == A_FLAG) ? regWrData : '0;

  always_comb begin
    strobe.flagClr = clrNow;
    strobe.rearm   = rearmQ;
  end

  always_comb begin
    case (regAddr)
      A_SEL0:  regRdData = selReg[0 +: DATA_W];
      A_SEL1:  regRdData = selReg[DATA_W +: DATA_W];
      A_EXP:   regRdData = expReg;
      A_EDGE:  regRdData = edgeReg;
      A_POL:   regRdData = polReg;
      A_EN:    regRdData = enReg;
      A_FLAG:  regRdData = flagIn;
      default: regRdData = '0;
    endcase
  end

  assign selCode  = selReg;
  assign expSel   = expReg;
  assign edgeMode = edgeReg;
  assign polHigh  = polReg;
  assign intEn    = enReg;
endmodule

// File: rtl/pisel_datapath.sv
module pisel_datapath
  import pisel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [PIN_W-1:0]         pinIn,
  input  logic [FACTORS*SEL_W-1:0] selCode,
  input  logic [FACTORS-1:0]       expSel,
  input  logic [FACTORS-1:0]       edgeMode,
  input  logic [FACTORS-1:0]       polHigh,
  input  logic [FACTORS-1:0]       intEn,
  input  pisel_strobe_t            strobe,
  output logic [FACTORS-1:0]       flagOut,
  output logic                     irqOut
);
  logic [PIN_W-1:0] syncStage [SYNC_STAGES];
  logic [PIN_W-1:0] syncPins;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < SYNC_STAGES; k++) syncStage[k] <= '0;
    end else begin
      syncStage[0] <= pinIn;
      for (int k = 1; k < SYNC_STAGES; k++) syncStage[k] <= syncStage[k-1];
    end
  end

  assign syncPins = syncStage[SYNC_STAGES-1];

  genvar n;
  generate
    for (n = 0; n < FACTORS; n++) begin : g_factor
      logic [CANDS-1:0] cand;
      logic srcVal, prevQ, flagQ;
      logic activeNow, edgeHit, setNow, clrNow;

      assign cand      = syncPins[n*CANDS +: CANDS];
      assign srcVal    = expSel[n] ? cand[CANDS-1] : cand[selCode[n*SEL_W +: SEL_W]];
      assign activeNow = (srcVal == polHigh[n]);
      assign edgeHit   = activeNow && (prevQ != polHigh[n]) && !strobe.rearm[n];
      assign setNow    = edgeMode[n] ? edgeHit : activeNow;
      assign clrNow    = strobe.flagClr[n];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          prevQ <= 1'b0;
          flagQ <= 1'b0;
        end else begin
          prevQ <= srcVal;
          if (edgeMode[n]) flagQ <= (flagQ && !clrNow) || setNow;
          else             flagQ <= !clrNow && (flagQ || setNow);
        end
      end

      assign flagOut[n] = flagQ;
    end
  endgenerate

  assign irqOut = |(flagOut & intEn);
endmodule

// File: rtl/port_irq_selector.sv
module port_irq_selector
  import pisel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [PIN_W-1:0]    pinIn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWrEn,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  output logic [FACTORS-1:0]  flagOut,
  output logic                irqOut
);
  logic [FACTORS*SEL_W-1:0] selCode;
  logic [FACTORS-1:0] expSel, edgeMode, polHigh, intEn;
  pisel_strobe_t strobe;

  pisel_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .flagIn(flagOut), .regRdData(regRdData),
    .selCode(selCode), .expSel(expSel), .edgeMode(edgeMode),
    .polHigh(polHigh), .intEn(intEn), .strobe(strobe)
  );

  pisel_datapath #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .selCode(selCode),
    .expSel(expSel), .edgeMode(edgeMode), .polHigh(polHigh),
    .intEn(intEn), .strobe(strobe), .flagOut(flagOut), .irqOut(irqOut)
  );
endmodule

// File: rtl/port_irq_selector_chk.sv
module port_irq_selector_chk
  import pisel_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   regAddr,
  input logic                regWrEn,
  input logic [DATA_W-1:0]   regWrData,
  input logic [DATA_W-1:0]   regRdData,
  input logic [FACTORS-1:0]  flagOut,
  input logic                irqOut
);
  // R1
  flags_reset_chk: assert property (@(posedge clk) !rstN |=> flagOut == '0);

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (flagOut != '0));

  // R9
  irq_disable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == A_EN && regWrData == '0) |=> !irqOut);

  // R2
  readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr < A_FLAG) |=>
      (regAddr != $past(regAddr)) || (regRdData == $past(regWrData)));

  genvar i;
  generate
    for (i = 0; i < FACTORS; i++) begin : g_flag
      // R8
      flag_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
        $fell(flagOut[i]) |-> $past(regWrEn && regAddr == A_FLAG && regWrData[i]));
    end
  endgenerate
endmodule

bind port_irq_selector port_irq_selector_chk chk_i (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
  .regWrData(regWrData), .regRdData(regRdData), .flagOut(flagOut), .irqOut(irqOut)
);

// File: tb/port_irq_selector_tb_top.sv
module port_irq_selector_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [39:0] pinIn = '0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic [7:0]  flagOut;
  logic        irqOut;

  int vectors = 0;
  int errors = 0;
  logic [7:0] selM [2];
  logic [7:0] expM, edgeM, polM;

  always #4 clk = ~clk;

  port_irq_selector dut_i (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .flagOut(flagOut), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic flagBit(input int n, output logic b);
    logic [7:0] v;
    rd(3'd6, v);
    b = v[n];
  endtask

  task automatic pushCfg();
    wr(3'd0, selM[0]); wr(3'd1, selM[1]);
    wr(3'd2, expM); wr(3'd3, edgeM); wr(3'd4, polM);
  endtask

  // one factor, one candidate, one trigger condition
  task automatic runCase(input int n, input int s, input bit edg, input bit pol);
    logic b;
    logic idle;
    int u;
    string tag;
    idle = ~pol;
    u = n * 5 + ((s + 1) % 5);
    tag = (s == 4) ? "R4" : "R3";
    pinIn = idle ? '1 : '0;
    waitCyc(4);
    if (s < 4) selM[n/4][(n%4)*2 +: 2] = 2'(s);
    expM[n] = (s == 4);
    edgeM[n] = edg;
    polM[n] = pol;
    pushCfg();
    waitCyc(4);
    wr(3'd6, 8'hFF);
    flagBit(n, b); check("R8 clear", {7'd0, b}, 8'd0);
    pinIn[u] = pol; waitCyc(4);
    flagBit(n, b); check("R5 stray active", {7'd0, b}, 8'd0);
    pinIn[u] = idle; waitCyc(4);
    flagBit(n, b); check("R5 stray idle", {7'd0, b}, 8'd0);
    pinIn[n*5+s] = pol; waitCyc(3);
    flagBit(n, b); check({tag, edg ? " R6 edge" : " R7 level"}, {7'd0, b}, 8'd1);
    wr(3'd5, 8'h00); #1 check("R9 gated", {7'd0, irqOut}, 8'd0);
    wr(3'd5, 8'(1 << n)); #1 check("R9 enabled", {7'd0, irqOut}, 8'd1);
    if (edg) begin
      wr(3'd6, 8'(1 << n)); waitCyc(4);
      flagBit(n, b); check("R6 held level", {7'd0, b}, 8'd0);
      pinIn[n*5+s] = idle; waitCyc(4);
      flagBit(n, b); check("R6 opposite edge", {7'd0, b}, 8'd0);
    end else begin
      wr(3'd6, 8'(1 << n)); waitCyc(1);
      flagBit(n, b); check("R7 reassert", {7'd0, b}, 8'd1);
      pinIn[n*5+s] = idle; waitCyc(4);
      wr(3'd6, 8'(1 << n)); waitCyc(2);
      flagBit(n, b); check("R7 inactive", {7'd0, b}, 8'd0);
    end
    wr(3'd5, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic b;
    selM[0] = '0; selM[1] = '0; expM = '0; edgeM = '0; polM = '0;
    waitCyc(3);
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v); check("R1 reset reg", v, 8'd0);
    end
    check("R1 reset irq", {7'd0, irqOut}, 8'd0);
    rstN = 1'b1;
    waitCyc(2);

    // R2 readback and address 7
    for (int a = 0; a < 6; a++) wr(3'(a), 8'hA5 ^ 8'(a * 17));
    wr(3'd7, 8'hFF);
    rd(3'd7, v); check("R2 addr7", v, 8'd0);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v); check("R2 readback", v, 8'hA5 ^ 8'(a * 17));
    end
    wr(3'd5, 8'h00);

    // sweep: every factor, every candidate, all four trigger conditions
    for (int n = 0; n < 8; n++)
      for (int s = 0; s < 5; s++)
        for (int m = 0; m < 4; m++)
          runCase(n, s, m[1], m[0]);

    // R10: switching source under a standing difference
    selM[0] = '0; selM[1] = '0; expM = '0; edgeM = 8'h01; polM = 8'h01;
    pinIn = '0; pinIn[1] = 1'b1; pinIn[4] = 1'b1;
    pushCfg(); waitCyc(4);
    wr(3'd6, 8'hFF); waitCyc(2);
    flagBit(0, b); check("R10 baseline", {7'd0, b}, 8'd0);
    selM[0][1:0] = 2'd1; wr(3'd0, selM[0]); waitCyc(4);
    flagBit(0, b); check("R10 code switch", {7'd0, b}, 8'd0);
    pinIn[1] = 1'b0; waitCyc(4); pinIn[1] = 1'b1; waitCyc(4);
    flagBit(0, b); check("R10 real edge", {7'd0, b}, 8'd1);
    selM[0][1:0] = 2'd0; wr(3'd0, selM[0]); waitCyc(4);
    wr(3'd6, 8'hFF); waitCyc(2);
    expM[0] = 1'b1; wr(3'd2, expM); waitCyc(4);
    flagBit(0, b); check("R10 override switch", {7'd0, b}, 8'd0);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule